// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR memory interface and walks the memory from power-on to a usable state. After a start pulse it keeps the clock-enable pin low for a programmable stabilization period. It then raises clock-enable during an idle cycle and issues a fixed series of commands on the chip-select, row-strobe, column-strobe, write-enable, bank and address pins. The series covers the precharges, the mode register writes that turn on and reset the DLL, the auto-refreshes and the final mode register write.

Each wait between commands comes from a cycle-count input: stabilization, precharge recovery, refresh recovery and mode-write recovery. The DLL lock interval after the DLL reset write is a parameter. The done flag tells the normal scheduler that it may take over the pins. Every cycle that carries no command drives the idle (no-operation) pattern.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is asserted (asynchronously), and afterwards until start_i is seen high, cke_o is 0, the pins show the idle pattern (cs_no=0, ras_no=1, cas_no=1, we_no=1), ba_o and addr_o are zero, and done_o is 0.
- R2: Counting the first cycle after the start edge as cycle 0, cke_o stays 0 for max(stab_cycles_i,1) cycles with idle pins. In cycle max(stab_cycles_i,1) it rises while the pins stay idle, and it never falls again before reset.
- R3: Commands are encoded {cs_no,ras_no,cas_no,we_no} as precharge 0010, auto-refresh 0001 and mode write 0000. Every cycle without a command is idle, 0111, with ba_o and addr_o zero.
- R4: Commands come in this order: precharge, extended mode write, DLL-reset mode write, precharge, N_REF auto-refreshes (default 2), final mode write.
- R5: Both precharges drive addr_o bit 10 high (all banks), with ba_o and every other address bit zero.
- R6: The extended mode write drives ba_o=01 (bank bit 0 high) and addr_o all zero, which enables the DLL.
- R7: The DLL-reset mode write drives ba_o=00, addr_o bit 8 high and bit 7 low. All other address bits come from the mode word captured at start.
- R8: The final mode write drives ba_o=00 and clears addr_o bits 8 and 7. All other bits come from the captured mode word.
- R9: The first precharge comes one cycle after cke_o rises. Each command is followed by exactly max(t,1) cycles before the next one. t is trp_cycles_i after a precharge, tmrd_cycles_i after a mode write and trfc_cycles_i after an auto-refresh.
- R10: done_o rises in the later of two cycles: max(tmrd_cycles_i,1) cycles after the final mode write, or LOCK_CYC (default 200) cycles after the DLL-reset write. It then stays high with cke_o high and idle pins.
- R11: start_i is ignored once a sequence has begun, both during the sequence and after done_o.
- R12: The mode word is captured at start. Changes to mode_word_i after that do not affect the values driven in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the sequence when idle |
| stab_cycles_i | input | CNT_W | Stabilization wait with clock-enable low, in cycles |
| trp_cycles_i | input | CNT_W | Precharge recovery, in cycles |
| trfc_cycles_i | input | CNT_W | Refresh recovery, in cycles |
| tmrd_cycles_i | input | CNT_W | Mode write recovery, in cycles |
| mode_word_i | input | ADDR_W | Operating mode word for the final mode write |
| cke_o | output | 1 | Memory clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Initialization complete |

## Verification
The spacing and lock checks read the three recovery inputs live. They therefore take for granted that trp_cycles_i, trfc_cycles_i and tmrd_cycles_i stay constant from start until done_o. The stimulus changes those inputs only while reset is held. The only input it changes during a run is mode_word_i, together with start_i pulses, and both are meant to be ignored by then. The lock check also assumes that every mode write with bank 00 and address bit 8 set is the DLL reset. The stimulus keeps to that.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_STAB, S_CKE_UP, S_PRE1, S_EMRS, S_MRS_DLL,
    S_PRE2, S_REF, S_MRS_FIN, S_GAP, S_LOCK, S_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  // count reaches zero on the next edge
  assign last_o = (cnt_q <= W'(1));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int AP_BIT     = 10,
  parameter int DLLRST_BIT = 8,
  parameter int TM_BIT     = 7
) (
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] mode_i,
  output cmd_t              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o
);

  localparam logic [BA_W-1:0] BA_EXT = BA_W'(1);

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    cke_o  = !(step_i inside {S_IDLE, S_STAB});
    unique case (step_i)
      S_PRE1, S_PRE2: begin
        cmd_o          = CMD_PRE;
        addr_o[AP_BIT] = 1'b1;
      end
      S_EMRS: begin
        cmd_o = CMD_MRS;
        ba_o  = BA_EXT;
      end
      S_MRS_DLL: begin
        cmd_o              = CMD_MRS;
        addr_o             = mode_i;
        addr_o[DLLRST_BIT] = 1'b1;
        addr_o[TM_BIT]     = 1'b0;
      end
      S_MRS_FIN: begin
        cmd_o              = CMD_MRS;
        addr_o             = mode_i;
        addr_o[DLLRST_BIT] = 1'b0;
        addr_o[TM_BIT]     = 1'b0;
      end
      S_REF: cmd_o = CMD_REF;
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int N_REF      = 2,
  parameter int LOCK_CYC   = 200,
  parameter int AP_BIT     = 10,
  parameter int DLLRST_BIT = 8,
  parameter int TM_BIT     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  stab_cycles_i,
  input  logic [CNT_W-1:0]  trp_cycles_i,
  input  logic [CNT_W-1:0]  trfc_cycles_i,
  input  logic [CNT_W-1:0]  tmrd_cycles_i,
  input  logic [ADDR_W-1:0] mode_word_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int REF_W  = $clog2(N_REF + 1);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);
  localparam logic [REF_W-1:0]  REF_LAST = REF_W'(N_REF - 1);
  localparam logic [LOCK_W-1:0] LOCK_LD  = LOCK_W'(LOCK_CYC - 1);

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] x);
    return (x == '0) ? CNT_W'(1) : x;
  endfunction

  function automatic step_e resolve(input step_e tgt, input logic lock_last);
    return (tgt == S_LOCK && lock_last) ? S_DONE : tgt;
  endfunction

  step_e             state_q, state_d, ret_q, ret_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic [ADDR_W-1:0] mode_q;
  logic              gap_load, gap_last, lock_last;
  logic [CNT_W-1:0]  gap_val, gap_cnt;
  logic [LOCK_W-1:0] lock_cnt;
  cmd_t              cmd;

  ddr_init_timer #(.W(CNT_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (gap_load),
    .load_val_i (gap_val),
    .cnt_o      (gap_cnt),
    .last_o     (gap_last)
  );

  ddr_init_timer #(.W(LOCK_W)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_q == S_MRS_DLL),
    .load_val_i (LOCK_LD),
    .cnt_o      (lock_cnt),
    .last_o     (lock_last)
  );

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    ref_d    = ref_q;
    gap_load = 1'b0;
    gap_val  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        gap_load = 1'b1;
        gap_val  = at_least_one(stab_cycles_i);
        state_d  = S_STAB;
      end
      S_STAB:   if (gap_last) state_d = S_CKE_UP;
      S_CKE_UP: state_d = S_PRE1;
      S_PRE1: begin
        gap_load = 1'b1;
        gap_val  = at_least_one(trp_cycles_i) - 1'b1;
        ret_d    = S_EMRS;
        state_d  = (gap_val == '0) ? ret_d : S_GAP;
      end
      S_EMRS: begin
        gap_load = 1'b1;
        gap_val  = at_least_one(tmrd_cycles_i) - 1'b1;
        ret_d    = S_MRS_DLL;
        state_d  = (gap_val == '0) ? ret_d : S_GAP;
      end
      S_MRS_DLL: begin
        gap_load = 1'b1;
        gap_val  = at_least_one(tmrd_cycles_i) - 1'b1;
        ret_d    = S_PRE2;
        state_d  = (gap_val == '0) ? ret_d : S_GAP;
      end
      S_PRE2: begin
        ref_d    = '0;
        gap_load = 1'b1;
        gap_val  = at_least_one(trp_cycles_i) - 1'b1;
        ret_d    = S_REF;
        state_d  = (gap_val == '0) ? ret_d : S_GAP;
      end
      S_REF: begin
        ref_d    = ref_q + 1'b1;
        gap_load = 1'b1;
        gap_val  = at_least_one(trfc_cycles_i) - 1'b1;
        ret_d    = (ref_q == REF_LAST) ? S_MRS_FIN : S_REF;
        state_d  = (gap_val == '0) ? ret_d : S_GAP;
      end
      S_MRS_FIN: begin
        gap_load = 1'b1;
        gap_val  = at_least_one(tmrd_cycles_i) - 1'b1;
        ret_d    = S_LOCK;
        state_d  = (gap_val == '0) ? resolve(S_LOCK, lock_last) : S_GAP;
      end
      S_GAP:  if (gap_last) state_d = resolve(ret_q, lock_last);
      S_LOCK: if (lock_last) state_d = S_DONE;
      S_DONE: ;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      ref_q   <= '0;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      ref_q   <= ref_d;
      if (state_q == S_IDLE && start_i) mode_q <= mode_word_i;
    end
  end

  ddr_init_cmd_enc #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .AP_BIT     (AP_BIT),
    .DLLRST_BIT (DLLRST_BIT),
    .TM_BIT     (TM_BIT)
  ) u_enc (
    .step_i (state_q),
    .mode_i (mode_q),
    .cmd_o  (cmd),
    .ba_o   (ba_o),
    .addr_o (addr_o),
    .cke_o  (cke_o)
  );

  assign cs_no  = cmd.cs_n;
  assign ras_no = cmd.ras_n;
  assign cas_no = cmd.cas_n;
  assign we_no  = cmd.we_n;
  assign done_o = (state_q == S_DONE);

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int LOCK_CYC   = 200,
  parameter int AP_BIT     = 10,
  parameter int DLLRST_BIT = 8,
  parameter int TM_BIT     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  trp_cycles_i,
  input logic [CNT_W-1:0]  trfc_cycles_i,
  input logic [CNT_W-1:0]  tmrd_cycles_i,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  logic is_nop, is_pre, is_ref, is_mrs, is_dllrst;
  assign is_nop = !cs_no &&  ras_no &&  cas_no &&  we_no;
  assign is_pre = !cs_no && !ras_no &&  cas_no && !we_no;
  assign is_ref = !cs_no && !ras_no && !cas_no &&  we_no;
  assign is_mrs = !cs_no && !ras_no && !cas_no && !we_no;
  assign is_dllrst = is_mrs && (ba_o == '0) && addr_o[DLLRST_BIT];

  function automatic logic [CNT_W-1:0] need(input logic [CNT_W-1:0] x);
    return ((x == '0) ? CNT_W'(1) : x) - 1'b1;
  endfunction

  logic [CNT_W-1:0]  quiet_q;
  logic [LOCK_W-1:0] since_q;
  logic              seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= '0;
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (is_pre)              quiet_q <= need(trp_cycles_i);
      else if (is_ref)         quiet_q <= need(trfc_cycles_i);
      else if (is_mrs)         quiet_q <= need(tmrd_cycles_i);
      else if (quiet_q != '0)  quiet_q <= quiet_q - 1'b1;
      if (is_dllrst) begin
        seen_q  <= 1'b1;
        since_q <= LOCK_W'(1);
      end else if (seen_q && since_q != LOCK_W'(LOCK_CYC)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  a_r1_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_no);
  a_r2_idle_while_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);
  a_r2_cke_never_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(cke_o));
  a_r5_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[AP_BIT] && ba_o == '0);
  a_r6_ext_write_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o == BA_W'(1)) |-> addr_o == '0);
  a_r8_normal_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> !ba_o[BA_W-1] && !addr_o[TM_BIT]);
  a_r9_recovery_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q != '0) |-> is_nop);
  a_r10_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> is_nop && cke_o);
  a_r10_lock_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> seen_q && since_q == LOCK_W'(LOCK_CYC));

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .LOCK_CYC   (LOCK_CYC),
  .AP_BIT     (AP_BIT),
  .DLLRST_BIT (DLLRST_BIT),
  .TM_BIT     (TM_BIT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trp_cycles_i  (trp_cycles_i),
  .trfc_cycles_i (trfc_cycles_i),
  .tmrd_cycles_i (tmrd_cycles_i),
  .cke_o         (cke_o),
  .cs_no         (cs_no),
  .ras_no        (ras_no),
  .cas_no        (cas_no),
  .we_no         (we_no),
  .ba_o          (ba_o),
  .addr_o        (addr_o),
  .done_o        (done_o)
);

// File: tb/ddr_pwrup_seq_test.sv
module ddr_pwrup_seq_test;

  localparam int LOCK = 200;

  typedef struct packed {
    logic [15:0] w;
    logic [15:0] trp;
    logic [15:0] trfc;
    logic [15:0] tmrd;
    logic [11:0] mode;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{w: 16'd5,  trp: 16'd3, trfc: 16'd7,   tmrd: 16'd2, mode: 12'h032},
    '{w: 16'd0,  trp: 16'd0, trfc: 16'd0,   tmrd: 16'd0, mode: 12'h0A3},
    '{w: 16'd40, trp: 16'd4, trfc: 16'd100, tmrd: 16'd3, mode: 12'h1FF},
    '{w: 16'd1,  trp: 16'd2, trfc: 16'd97,  tmrd: 16'd2, mode: 12'h062},
    '{w: 16'd12, trp: 16'd6, trfc: 16'd20,  tmrd: 16'd5, mode: 12'hFFF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] stab_cycles_i = '0, trp_cycles_i = '0, trfc_cycles_i = '0, tmrd_cycles_i = '0;
  logic [11:0] mode_word_i = '0;
  logic        cke_o, cs_no, ras_no, cas_no, we_no, done_o;
  logic [1:0]  ba_o;
  logic [11:0] addr_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  ddr_pwrup_seq uut (
    .clk_i, .rst_ni, .start_i, .stab_cycles_i, .trp_cycles_i, .trfc_cycles_i,
    .tmrd_cycles_i, .mode_word_i, .cke_o, .cs_no, .ras_no, .cas_no, .we_no,
    .ba_o, .addr_o, .done_o
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int clamp1(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  // R1: idle pins, cke low, done low, zero address
  task automatic check_reset_state(input string tag);
    check(tag, {cke_o, cs_no, ras_no, cas_no, we_no, ba_o, addr_o, done_o},
          {1'b0, 4'b0111, 2'b00, 12'h000, 1'b0});
  endtask

  task automatic run_vec(input vec_t v, input bit disturb);
    int wp, p, f, m;
    int t_pre1, t_emrs, t_mrs1, t_pre2, t_ref1, t_ref2, t_mrs2, t_done;
    logic [11:0] m1, m2;
    wp = clamp1(int'(v.w)); p = clamp1(int'(v.trp));
    f = clamp1(int'(v.trfc)); m = clamp1(int'(v.tmrd));
    t_pre1 = wp + 1;      t_emrs = t_pre1 + p;  t_mrs1 = t_emrs + m;
    t_pre2 = t_mrs1 + m;  t_ref1 = t_pre2 + p;  t_ref2 = t_ref1 + f;
    t_mrs2 = t_ref2 + f;
    t_done = (t_mrs2 + m > t_mrs1 + LOCK) ? t_mrs2 + m : t_mrs1 + LOCK;
    m1 = (v.mode | 12'h100) & ~12'h080;
    m2 = v.mode & ~12'h180;

    @(negedge clk_i);
    rst_ni = 1'b0;
    stab_cycles_i = v.w; trp_cycles_i = v.trp; trfc_cycles_i = v.trfc;
    tmrd_cycles_i = v.tmrd; mode_word_i = v.mode;
    @(negedge clk_i);
    check_reset_state("R1 in reset");
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check_reset_state("R1 before start");
    end
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n <= t_done + 30; n++) begin
      logic [3:0]  ec;
      logic [1:0]  eb;
      logic [11:0] ea;
      string       tag;
      ec = 4'b0111; eb = 2'b00; ea = 12'h000; tag = "R3 idle,R9";
      if (n == t_pre1 || n == t_pre2) begin ec = 4'b0010; ea = 12'h400; tag = "R5,R4,R9"; end
      if (n == t_emrs) begin ec = 4'b0000; eb = 2'b01; tag = "R6,R4,R9"; end
      if (n == t_mrs1) begin ec = 4'b0000; ea = m1; tag = "R7,R12,R9"; end
      if (n == t_ref1 || n == t_ref2) begin ec = 4'b0001; tag = "R4 refresh,R9"; end
      if (n == t_mrs2) begin ec = 4'b0000; ea = m2; tag = "R8,R12,R9"; end
      check(tag, {cs_no, ras_no, cas_no, we_no, ba_o, addr_o}, {ec, eb, ea});
      check("R2 cke", cke_o, (n >= wp));
      check("R10 done", done_o, (n >= t_done));
      if (disturb) begin
        if (n == 2) mode_word_i = ~v.mode;                    // R12
        if (n == t_ref1 || n == t_done + 5) start_i = 1'b1;   // R11
        else start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R10: watchdog expired, got running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check_reset_state("R1 time zero");
    foreach (VECS[i]) run_vec(VECS[i], i[0]);
    run_vec(VECS[0], 1'b1);

    // R1: asynchronous reset in the middle of a sequence
    @(negedge clk_i);
    rst_ni = 1'b0;
    stab_cycles_i = 16'd2; trp_cycles_i = 16'd2; trfc_cycles_i = 16'd3;
    tmrd_cycles_i = 16'd2; mode_word_i = 12'h031;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R2 cke mid-run", cke_o, 1'b1);
    #1 rst_ni = 1'b0;
    #1 check_reset_state("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check_reset_state("R1 after reset, no start");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule